// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one unsigned integer by another over several clock cycles. A caller places a dividend and a divisor on the operand inputs and pulses `start` for one cycle. The block then works out one quotient bit per clock. It begins with the most significant dividend bit and moves toward the least significant. On each step it tries subtracting the divisor from the partial remainder. If the trial is not negative, the block keeps the difference and records a 1. If it is negative, the block keeps the old partial remainder and records a 0.

The sequence is run by a three-state controller. `ST_IDLE` is the state after reset. `ST_BUSY` resolves the quotient bits. `ST_DONE` presents a finished result. The transitions are named as follows:
- *accept* moves `ST_IDLE` to `ST_BUSY`, and also `ST_DONE` to `ST_BUSY`, when `start` is high.
- *step* keeps the controller in `ST_BUSY` while bits remain.
- *finish* moves `ST_BUSY` to `ST_DONE` on the last bit.
- *hold* keeps `ST_IDLE` or `ST_DONE` when `start` is low.

The cycle that captures the operands counts as the first of the WIDTH+1 cycles. A divisor of zero is a defined case: it gives a quotient of zero and a remainder of zero.

Top module: `seq_div`

## Requirements
- R1: While reset (synchronous, active high) is applied and right after it, `done` is 0 and `quotient` and `remainder` are 0.
- R2: A `start` sampled high in `ST_IDLE` or `ST_DONE` captures both operands, and `done` is 0 in the following cycle.
- R3: `done` rises exactly WIDTH+1 cycles after an accepted start, counting the accepting cycle as the first; it is 0 in every cycle before that.
- R4: For a nonzero divisor, the final values satisfy dividend = quotient*divisor + remainder with remainder < divisor.
- R5: When the dividend is smaller than a nonzero divisor, the quotient is 0 and the remainder equals the dividend.
- R6: A zero divisor yields quotient 0 and remainder 0.
- R7: `start` is ignored in `ST_BUSY`, including the final resolving cycle; the result and the timing of `done` are those of the division already running.
- R8: Once high, `done` and both result outputs hold their values until the next accepted start.
- R9: While a division runs, `quotient` and `remainder` keep the values of the previous result (0 after reset).
- R10: With WIDTH=8: 10/7 gives 1 r 3, 100/100 gives 1 r 0, 100/7 gives 14 r 2, 100/0 gives 0 r 0, 70/150 gives 0 r 70.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division; sampled only outside `ST_BUSY` |
| dividend | input | WIDTH | Unsigned dividend, captured on accept |
| divisor | input | WIDTH | Unsigned divisor, captured on accept |
| quotient | output | WIDTH | Final quotient |
| remainder | output | WIDTH | Final remainder |
| done | output | 1 | High while a finished result is presented |

## Verification
A new start can arrive in the same cycle as the finish of the division in flight. In that cycle the controller is still in `ST_BUSY`, so the start must be dropped. The bench provokes this by raising `start` with different operands exactly in the last resolving cycle. It then checks three things: `done` rises on schedule, the result belongs to the first operands, and `done` stays high on the next cycle. A second pattern raises `start` in `ST_DONE`, where it must be accepted. The bench checks that `done` falls in the following cycle while the old result is still shown.

// File: rtl/divq_pkg.sv
package divq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } divq_state_e;
endpackage

// File: rtl/divq_ctrl.sv
module divq_ctrl
    import divq_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output divq_state_e state_q,
    output logic        accept,
    output logic        step_en,
    output logic        last_step
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    divq_state_e state_d;
    logic [CW-1:0] cnt_q;

    assign accept    = start && (state_q != ST_BUSY);
    assign step_en   = (state_q == ST_BUSY);
    assign last_step = step_en && (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_BUSY;
            ST_BUSY: if (cnt_q == LAST) state_d = ST_DONE;
            ST_DONE: if (start) state_d = ST_BUSY;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (accept)  cnt_q <= '0;
        else if (step_en) cnt_q <= cnt_q + 1'b1;
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        step_en |-> (cnt_q <= LAST));
    // R3
    finish_to_done_chk: assert property (@(posedge clk) disable iff (rst)
        last_step |=> (state_q == ST_DONE));
    // R7
    busy_ignores_start_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && !last_step) |=> (state_q == ST_BUSY));
endmodule

// File: rtl/divq_trial.sv
module divq_trial #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem_in,
    input  logic             bit_in,
    input  logic [WIDTH-1:0] dvs,
    output logic [WIDTH-1:0] rem_out,
    output logic             q_bit
);
    localparam int TW = WIDTH + 2;

    logic [TW-1:0] shifted;
    logic [TW-1:0] diff;
    logic          neg;

    always_comb begin
        shifted = {1'b0, rem_in, bit_in};
        diff    = shifted - {2'b00, dvs};
        neg     = diff[TW-1];
        q_bit   = !neg;
        rem_out = neg ? shifted[WIDTH-1:0] : diff[WIDTH-1:0];
    end
endmodule

// File: rtl/divq_path.sv
module divq_path #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             step_en,
    input  logic             last_step,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);
    logic [WIDTH-1:0] rem_q;
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] dvs_q;
    logic [WIDTH-1:0] rem_next;
    logic             q_bit;

    divq_trial #(.WIDTH(WIDTH)) u_trial (
        .rem_in  (rem_q),
        .bit_in  (acc_q[WIDTH-1]),
        .dvs     (dvs_q),
        .rem_out (rem_next),
        .q_bit   (q_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            acc_q <= '0;
            dvs_q <= '0;
        end else if (accept) begin
            rem_q <= '0;
            acc_q <= dividend;
            dvs_q <= divisor;
        end else if (step_en) begin
            rem_q <= rem_next;
            acc_q <= {acc_q[WIDTH-2:0], q_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quotient  <= '0;
            remainder <= '0;
        end else if (last_step) begin
            if (dvs_q == '0) begin
                quotient  <= '0;
                remainder <= '0;
            end else begin
                quotient  <= {acc_q[WIDTH-2:0], q_bit};
                remainder <= rem_next;
            end
        end
    end

    // R4
    partial_rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && dvs_q != '0) |-> (rem_q < dvs_q));
    // R6
    zero_divisor_result_chk: assert property (@(posedge clk) disable iff (rst)
        (last_step && dvs_q == '0) |=> (quotient == '0 && remainder == '0));
endmodule

// File: rtl/seq_div.sv
module seq_div
    import divq_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             done
);
    localparam int LW = $clog2(WIDTH + 2) + 1;

    divq_state_e state_q;
    logic        accept;
    logic        step_en;
    logic        last_step;

    divq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .state_q   (state_q),
        .accept    (accept),
        .step_en   (step_en),
        .last_step (last_step)
    );

    divq_path #(.WIDTH(WIDTH)) u_path (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .step_en   (step_en),
        .last_step (last_step),
        .dividend  (dividend),
        .divisor   (divisor),
        .quotient  (quotient),
        .remainder (remainder)
    );

    assign done = (state_q == ST_DONE);

    logic [LW-1:0] lat_q;
    always_ff @(posedge clk) begin
        if (rst)                lat_q <= '1;
        else if (accept)        lat_q <= LW'(1);
        else if (lat_q != '1)   lat_q <= lat_q + 1'b1;
    end

    // R2
    done_drops_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !done);
    // R3
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (lat_q == LW'(WIDTH + 1)));
    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(quotient) && $stable(remainder)));
    // R9
    busy_outputs_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && !last_step) |=> ($stable(quotient) && $stable(remainder)));
endmodule

// File: tb/sim_seq_div.sv
module sim_seq_div;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [W-1:0] prev_q = '0;
    logic [W-1:0] prev_r = '0;

    always #2 clk = ~clk;

    seq_div #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .dividend(dividend), .divisor(divisor),
        .quotient(quotient), .remainder(remainder), .done(done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycles=%0d expected < 150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Runs one division; optionally pokes start mid-run (R7) or in the final cycle.
    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                           input int poke_at);
        int eq, er;
        if (b == 0) begin eq = 0; er = 0; end
        else begin eq = a / b; er = a % b; end
        @(negedge clk);
        start = 1'b1; dividend = a; divisor = b;
        @(negedge clk);           // after the accepting edge
        start = 1'b0;
        dividend = ~a; divisor = b + 8'd3;
        check(done == 1'b0, "R2 done low after accept", done, 0);
        check(quotient == prev_q && remainder == prev_r, "R9 previous result held",
              quotient, prev_q);
        for (int i = 1; i < W; i++) begin
            if (i == poke_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (i == W - 1)
                check(done == 1'b0, "R3 done low before last edge", done, 0);
        end
        if (poke_at == W) start = 1'b1;
        @(negedge clk);           // after edge accept+W
        start = 1'b0;
        check(done == 1'b1, "R3 done at WIDTH+1 cycles", done, 1);
        check(quotient == eq[W-1:0], (b == 0) ? "R6 zero divisor quotient" :
              (a < b) ? "R5 small dividend quotient" : "R4 quotient", quotient, eq);
        check(remainder == er[W-1:0], (b == 0) ? "R6 zero divisor remainder" :
              (a < b) ? "R5 small dividend remainder" : "R4 remainder", remainder, er);
        prev_q = eq[W-1:0];
        prev_r = er[W-1:0];
    endtask

    initial begin
        logic [W-1:0] dlist [12];
        dlist = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd7, 8'd13, 8'd64, 8'd100,
                  8'd127, 8'd150, 8'd200, 8'd255};
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done in reset", done, 0);
        check(quotient == 0 && remainder == 0, "R1 outputs in reset", quotient, 0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && quotient == 0 && remainder == 0, "R1 after reset",
              done, 0);

        // R10 fixed cases
        run_div(8'd10, 8'd7, 0);
        check(quotient == 1 && remainder == 3, "R10 10/7", quotient, 1);
        run_div(8'd100, 8'd100, 0);
        check(quotient == 1 && remainder == 0, "R10 100/100", quotient, 1);
        run_div(8'd100, 8'd7, 0);
        check(quotient == 14 && remainder == 2, "R10 100/7", quotient, 14);
        run_div(8'd100, 8'd0, 0);
        check(quotient == 0 && remainder == 0, "R10 100/0", quotient, 0);
        run_div(8'd70, 8'd150, 0);
        check(quotient == 0 && remainder == 70, "R10 70/150", remainder, 70);

        // R7 start mid-run and in the finishing cycle
        run_div(8'd200, 8'd13, 3);
        run_div(8'd255, 8'd2, W);
        @(negedge clk);
        check(done == 1'b1, "R7 late start dropped, done still high", done, 1);
        check(quotient == 127 && remainder == 1, "R7 result kept", quotient, 127);

        // R8 hold with start low
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(done == 1'b1 && quotient == 127 && remainder == 1,
                  "R8 done and result held", quotient, 127);
        end

        // near-exhaustive sweep
        for (int di = 0; di < 12; di++)
            for (int a = 0; a < 256; a++)
                run_div(a[W-1:0], dlist[di], 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule